// File: doc/BRIEF.md
# Serial EEPROM Read Target

This block is a two-wire bus target that answers reads from a 256-byte internal store. A system clock oversamples the bus clock and data lines. The block finds Start, repeated Start and Stop conditions and decodes the control byte. It drives the data line open-drain through an output enable, so a high on `sda_oe` pulls the line low.

One address pointer serves every access. A write transaction carries one word address, which loads the pointer. A read transaction returns the byte at the pointer. After each byte sent, the pointer steps by one. Three kinds of read work this way. A current-address read simply continues from where the pointer stands. A random read loads the pointer with a short write, then a repeated Start follows before the read. A sequential read goes on for as long as the master acknowledges each byte.

The store is a register array. A synchronous preload port fills it before any bus traffic starts.

Top module: `eeprom_rd_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0) and the pointer is 0, so the first current-address read returns the byte at address 0.
- R2: A falling SDA while SCL is high is a Start and begins control-byte reception. A rising SDA while SCL is high is a Stop. After a Stop the block is idle with SDA released.
- R3: The control byte is received MSB first. Bits [7:4] must be 4'b1010, bits [3:1] must equal `dev_sel[2:0]`, and bit 0 is R/W, where 1 means read. On a match the target pulls SDA low for the ninth clock as its acknowledge.
- R4: If either the device code or the select bits mismatch, the target does not acknowledge. SDA then stays released until the next Start, and the pointer does not change.
- R5: In a write (R/W = 0), the byte after the control byte is the word address. The target acknowledges it and loads it into the pointer. Any later byte in that same write gets no acknowledge.
- R6: A repeated Start after the word address ends the write but keeps the loaded pointer, so the read that follows returns the byte at that address.
- R7: Read data goes out MSB first. SDA changes only while SCL is low and holds steady while SCL is high.
- R8: The pointer steps by one at the end of every byte transmitted. A current-address read therefore returns the byte after the last one sent.
- R9: A master acknowledge (SDA low on the ninth clock) makes the target send the next sequential byte. A missing acknowledge makes it release SDA and wait for a Stop or Start.
- R10: During sequential reads the pointer wraps from 8'hFF to 8'h00.
- R11: A Start or Stop in the middle of a byte aborts that byte, and a partial byte leaves the pointer unchanged.
- R12: When `pre_we` is high at a clock edge, `pre_data` is written to `pre_addr`. That content is what later reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| dev_sel | input | 3 | Strapped device-select value compared with control bits [3:1] |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 8 | Preload address |
| pre_data | input | 8 | Preload data |

## Verification
The hardest case to reach from the ports is a byte cut short partway through. A cut-short byte must leave the pointer untouched, and its effect shows only in a later transaction. The bench clocks single bits by hand: part of a control byte, and part of a word address. It then issues a Start or Stop in the middle of the byte and follows with a current-address read whose expected byte comes from the unchanged model pointer. A sequential read that starts at 8'hFD exercises the wrap and the per-acknowledge continuation together.

// File: rtl/eeprom_rd_pkg.sv
// Shared types and constants for the serial EEPROM read target.
// Assumes an 8-bit data byte on the bus.
package eeprom_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } tgt_state_t;

    localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/bus_cond_detect.sv
// Synchronizes SCL and SDA into the system clock domain and flags clock
// edges plus Start and Stop conditions, one cycle each.
// Assumes the system clock runs at least 8x the SCL rate and the bus idles high.
module bus_cond_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_q;
    logic                   sda_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Single-stage capture of both lines.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end else begin : g_multi
            // Shift chain for metastability settling.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    // Previous synchronized levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_sh[LAST];
            sda_q <= sda_sh[LAST];
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_lvl   = scl_sh[LAST];
        sda_lvl   = sda_sh[LAST];
        scl_rise  = scl_lvl & ~scl_q;
        scl_fall  = ~scl_lvl & scl_q;
        start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
        stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;
    end

endmodule

// File: rtl/byte_store.sv
// Register-array byte store: one synchronous write port for preload and one
// combinational read port for the pointer.
// Assumes contents are loaded before use; the array has no reset.
module byte_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Preload write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Read at the current pointer.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/target_fsm.sv
// Bus protocol engine: receives the control and address bytes, acknowledges,
// shifts out read data MSB first and keeps the auto-incrementing pointer.
// Assumes one-cycle edge and condition strobes from bus_cond_detect and AW <= DW.
module target_fsm
    import eeprom_rd_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_evt,
    input  logic          stop_evt,
    input  logic          sda_lvl,
    input  logic [2:0]    dev_sel,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] ptr,
    output logic          sda_drive,
    output tgt_state_t    state
);
    localparam int            CW   = $clog2(DW + 1);
    localparam logic [CW-1:0] FULL = CW'(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic [DW-1:0] shreg;
    logic [CW-1:0] cnt;
    logic          rw;
    logic          mack_n;
    logic          id_match;

    // Control byte match against device code and select strap.
    assign id_match = (shreg[DW-1:DW-4] == DEV_CODE) && (shreg[3:1] == dev_sel);

    // Protocol sequencing, shift register and pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            shreg  <= '0;
            cnt    <= '0;
            ptr    <= '0;
            rw     <= 1'b0;
            mack_n <= 1'b1;
        end else if (stop_evt) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (start_evt) begin
            state <= ST_CTRL;
            cnt   <= '0;
        end else begin
            case (state)
                ST_CTRL, ST_ADDR: begin
                    if (scl_rise && cnt < FULL) begin
                        shreg <= {shreg[DW-2:0], sda_lvl};
                        cnt   <= cnt + CW'(1);
                    end else if (scl_fall && cnt == FULL) begin
                        cnt <= '0;
                        if (state == ST_CTRL) begin
                            if (id_match) begin
                                state <= ST_CTRL_ACK;
                                rw    <= shreg[0];
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else begin
                            ptr   <= AW'(shreg);
                            state <= ST_ADDR_ACK;
                        end
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            shreg <= rd_data;
                            state <= ST_TX;
                        end else begin
                            state <= ST_ADDR;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) state <= ST_SKIP;
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            ptr   <= ptr + AW'(1);
                            state <= ST_TX_ACK;
                        end else begin
                            shreg <= {shreg[DW-2:0], 1'b0};
                            cnt   <= cnt + CW'(1);
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        mack_n <= sda_lvl;
                    end else if (scl_fall) begin
                        if (!mack_n) begin
                            shreg <= rd_data;
                            state <= ST_TX;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Open-drain drive: acknowledge slots and zero data bits.
    always_comb begin
        case (state)
            ST_CTRL_ACK, ST_ADDR_ACK: sda_drive = 1'b1;
            ST_TX:                    sda_drive = ~shreg[DW-1];
            default:                  sda_drive = 1'b0;
        endcase
    end

endmodule

// File: rtl/eeprom_rd_target.sv
// Top of the serial EEPROM read target: line synchronizer and condition
// detector, protocol engine and byte store.
// Assumes an external pull-up and wired-AND on SDA; sda_oe high pulls low.
module eeprom_rd_target
    import eeprom_rd_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic [2:0]    dev_sel,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data
);
    logic          scl_lvl;
    logic          sda_lvl;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_evt;
    logic          stop_evt;
    logic [AW-1:0] ptr;
    logic [DW-1:0] rd_data;
    tgt_state_t    state;

    bus_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) det_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    byte_store #(.AW(AW), .DW(DW)) store_i (
        .clk     (clk),
        .wr_en   (pre_we),
        .wr_addr (pre_addr),
        .wr_data (pre_data),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

    target_fsm #(.AW(AW), .DW(DW)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_lvl   (sda_lvl),
        .dev_sel   (dev_sel),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .sda_drive (sda_oe),
        .state     (state)
    );

endmodule

// File: rtl/eeprom_rd_target_chk.sv
// Protocol checker for eeprom_rd_target, attached by bind.
// Assumes the bound top's internal strobes and pointer names.
module eeprom_rd_target_chk
    import eeprom_rd_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe,
    input logic          scl_fall,
    input logic          stop_evt,
    input logic [AW-1:0] ptr,
    input tgt_state_t    state
);
    // R7: the data line moves only while SCL is low.
    a_r7_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!scl_i && !$past(scl_i)));

    // R2: a Stop leaves the line released.
    a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    // R11: the pointer moves only on an SCL falling edge, never on a partial byte.
    a_r11_ptr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> $past(scl_fall));

    // R8 and R10: after a byte is sent the pointer steps by exactly one, wrapping.
    a_r10_ptr_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((ptr != $past(ptr)) && ($past(state) == ST_TX)) |-> (ptr == AW'($past(ptr) + 1'b1)));

    // R3: the acknowledge pull starts right after an SCL fall.
    a_r3_ack_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

endmodule

bind eeprom_rd_target eeprom_rd_target_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .scl_fall (scl_fall),
    .stop_evt (stop_evt),
    .ptr      (ptr),
    .state    (state)
);

// File: tb/eeprom_rd_target_tb_top.sv
// Scoreboard bench: reader tasks push expected bytes from a model store and
// pointer; a monitor process compares every byte the master clocks in.
module eeprom_rd_target_tb_top;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] dev_sel = 3'b101;
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    wire        sda_oe;
    wire        sda_bus = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    eeprom_rd_target dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .dev_sel  (dev_sel),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data)
    );

    int         n_chk = 0;
    int         n_err = 0;
    int         stab_err = 0;
    int         ptr_m = 0;
    logic [7:0] model_mem [256];
    logic [7:0] exp_q [$];
    logic [7:0] got;
    string      got_tag;
    event       got_ev;

    function automatic logic [7:0] pat(int i);
        return 8'(i * 37 + 11) ^ 8'h5A;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bstop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic put_bit(bit b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output bit b);
        bit late;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus; tick(Q - 1);
        late = sda_bus;
        if (late != b) stab_err++;
        tick(1);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(logic [7:0] v, output bit nack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(nack);
    endtask

    task automatic recv_byte(bit give_ack);
        bit b;
        logic [7:0] v = '0;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        got = v;
        -> got_ev;
        put_bit(!give_ack);
    endtask

    task automatic expect_bytes(int n);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(model_mem[ptr_m]);
            ptr_m = (ptr_m + 1) % 256;
        end
    endtask

    function automatic logic [7:0] ctrl(bit rd);
        return {4'b1010, dev_sel, rd};
    endfunction

    task automatic cur_read(int n, string tag);
        bit nack;
        bstart();
        send_byte(ctrl(1'b1), nack);
        check(nack == 1'b0, {tag, " R3 control ack"}, nack, 0);
        expect_bytes(n);
        got_tag = tag;
        for (int k = 0; k < n; k++) recv_byte(k != n - 1);
        bstop();
        check(sda_oe == 1'b0, {tag, " R2 released after stop"}, sda_oe, 0);
    endtask

    task automatic rand_read(int a, int n, string tag);
        bit nack;
        bstart();
        send_byte(ctrl(1'b0), nack);
        check(nack == 1'b0, {tag, " R3 write control ack"}, nack, 0);
        send_byte(8'(a), nack);
        check(nack == 1'b0, {tag, " R5 address ack"}, nack, 0);
        ptr_m = a;
        bstart();
        send_byte(ctrl(1'b1), nack);
        check(nack == 1'b0, {tag, " R6 read control ack"}, nack, 0);
        expect_bytes(n);
        got_tag = tag;
        for (int k = 0; k < n; k++) recv_byte(k != n - 1);
        bstop();
    endtask

    // Monitor: pop expected byte and compare with what the master clocked in.
    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, {got_tag, " scoreboard empty"}, got, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(got == e, got_tag, got, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    // Stimulus.
    initial begin
        bit nack;
        bit b;
        logic [7:0] v;
        tick(5);
        check(sda_oe == 1'b0, "R1 released in reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(2);
        check(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);

        // R12: preload the store through the preload port.
        for (int i = 0; i < 256; i++) begin
            pre_we = 1'b1;
            pre_addr = 8'(i);
            pre_data = pat(i);
            model_mem[i] = pat(i);
            tick(1);
        end
        pre_we = 1'b0;
        tick(4);

        cur_read(1, "R1 R12 first read from address 0");
        rand_read(8'h10, 1, "R6 random read");
        cur_read(1, "R8 current read after random");
        rand_read(8'hFD, 5, "R10 R9 sequential wrap");
        cur_read(2, "R8 R9 current read after wrap");

        // R4: wrong device code, read direction.
        bstart();
        send_byte({4'b1011, dev_sel, 1'b1}, nack);
        check(nack == 1'b1, "R4 wrong code not acked", nack, 1);
        v = '0;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        check(v == 8'hFF, "R4 line stays released", v, 8'hFF);
        bstop();
        cur_read(1, "R4 pointer kept after wrong code");

        // R4: wrong select bits, write direction with an address byte.
        bstart();
        send_byte({4'b1010, dev_sel ^ 3'b010, 1'b0}, nack);
        check(nack == 1'b1, "R4 wrong select not acked", nack, 1);
        send_byte(8'h40, nack);
        check(nack == 1'b1, "R4 address ignored", nack, 1);
        bstop();
        cur_read(1, "R4 pointer kept after wrong select");

        // R5: address-only write then Stop; data byte gets no ack.
        bstart();
        send_byte(ctrl(1'b0), nack);
        check(nack == 1'b0, "R5 write control ack", nack, 0);
        send_byte(8'h80, nack);
        check(nack == 1'b0, "R5 address ack", nack, 0);
        send_byte(8'h55, nack);
        check(nack == 1'b1, "R5 data byte not acked", nack, 1);
        bstop();
        ptr_m = 8'h80;
        cur_read(1, "R5 pointer loaded by write");

        // R11: repeated Start inside the address byte.
        bstart();
        send_byte(ctrl(1'b0), nack);
        check(nack == 1'b0, "R11 write control ack", nack, 0);
        for (int i = 7; i >= 3; i--) put_bit(v[i] ^ 1'b1);
        bstart();
        bstop();
        cur_read(1, "R11 partial address aborted");

        // R11: Stop inside the control byte.
        bstart();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bstop();
        check(sda_oe == 1'b0, "R11 released after aborted control", sda_oe, 0);
        cur_read(1, "R11 partial control aborted");

        rand_read(8'hFF, 2, "R10 wrap from last address");

        check(stab_err == 0, "R7 SDA stable while SCL high", stab_err, 0);
        check(exp_q.size() == 0, "R9 all expected bytes received", exp_q.size(), 0);
        tick(10);
        finish_run();
    end

endmodule